// File: doc/BRIEF.md
# Maskable Edge-Triggered Interrupt Controller

This block merges eight interrupt sources onto one active-low request line. The line is modelled as an output enable paired with a drive value that is always zero, so several such lines can share one wired-OR net. Six of the sources are frame events, one for each transmit and each receive direction of three channels. A rising edge on a source's event input is held until the next frame strobe of that same channel and direction. On that strobe the source's request bit sets. The other two sources summarise errors. Each is the OR of several error inputs, and every error input has its own enable bit. Every error input, enabled or not, is also captured in an error status register that empties when it is read.

A processor reaches the block through a simple register port: address, write data, write strobe, read strobe and registered read data. Software masks sources by writing ones and reads the pending requests. It acknowledges a request by writing a zero to the matching bit of the clear register. After reset every source is masked and every error enable is off, so the line stays released until software opens it.

Top module: `irq_gather`

## Requirements
- R1: After reset the mask register (offset 0) reads 0xFF, the error enable register (offset 4) reads 0x00, the request register (offset 1) reads 0x00, and `irq_oe` is 0.
- R2: Request register bit order: bits 0..2 are transmit frame events of channels 1..3, bits 3..5 are receive frame events of channels 1..3, bit 6 is the transmit error summary and bit 7 is the receive error summary.
- R3: A rising edge on a frame event input is remembered until a frame strobe for the same channel and direction. The request bit is set at the clock edge that samples that strobe, or at the edge that samples the rising edge if the strobe is high in the same cycle. Without a strobe the bit stays clear.
- R4: Events are edge-triggered. An event input held high across several strobes sets its request bit only once, and it must return low and rise again before it can set the bit again.
- R5: Writing 1 to a bit of the mask register (offset 0) masks that source. `irq_oe` is 1 exactly when some request bit is set whose mask bit is 0, and it changes at the same clock edge as the request or mask register. `irq_drv` is always 0.
- R6: A write to the clear register (offset 2) clears each request bit whose write-data bit is 0 and leaves each bit whose write-data bit is 1 unchanged. The clear register reads as 0x00.
- R7: If a source sets its request bit in the same cycle that a clear write targets that bit, the bit ends up set.
- R8: Error enable layout (offset 4): bits 0..2 are the channel 1..3 transmit errors, bits 3..5 are the channel 1..3 receive errors, and bit 6 is the PLL error. Request bit 6 sets when the OR of the enabled transmit errors rises. Request bit 7 sets when the OR of the enabled receive and PLL errors rises. A disabled error input never sets a request bit.
- R9: The error status register (offset 3) uses the same layout as R8. It latches every error input that is high, whether enabled or not. A read returns the current contents and then clears it, except that an error high in the cycle of the read stays latched.
- R10: Read data is registered. It appears at the clock edge that samples the read strobe and holds until the next read. Offsets above 4 read 0x00. Writes to offsets 1 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tx_frame | input | 3 | Per-channel transmit frame strobe |
| rx_frame | input | 3 | Per-channel receive frame strobe |
| tx_evt | input | 3 | Per-channel transmit frame event |
| rx_evt | input | 3 | Per-channel receive frame event |
| tx_err | input | 3 | Per-channel transmit error pulses |
| rx_err | input | 3 | Per-channel receive error pulses |
| pll_err | input | 1 | PLL error pulse |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| irq_oe | output | 1 | Request line enable (pull low when 1) |
| irq_drv | output | 1 | Request line drive value, always 0 |

## Verification
Every register result of this block is due exactly one clock edge after the stimulus that causes it. A request bit appears at the edge that samples the qualifying frame strobe. The mask, clear and enable writes take effect at the edge that samples the write strobe, and `irq_oe` follows at that same edge. Read data and the read-to-clear of the error status are also due one edge after the read strobe. The bench drives every input on the falling edge and samples on the following falling edge, one rising edge later. For each of the six frame sources and each of the seven error inputs, with its enable both on and off, it sweeps through the arm, strobe, mask, clear and re-arm steps, so every expected value is a single shifted bit.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;
    // register offsets; the bench and software depend on these values
    localparam int unsigned OFF_MASK  = 0;
    localparam int unsigned OFF_REQ   = 1;
    localparam int unsigned OFF_CLR   = 2;
    localparam int unsigned OFF_ESTAT = 3;
    localparam int unsigned OFF_EEN   = 4;
    localparam int unsigned OFF_LAST  = OFF_EEN;

    typedef enum logic [2:0] {
        SEL_MASK  = 3'd0,
        SEL_REQ   = 3'd1,
        SEL_CLR   = 3'd2,
        SEL_ESTAT = 3'd3,
        SEL_EEN   = 3'd4,
        SEL_NONE  = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/irq_frame_src.sv
// One frame-aligned source: remembers a rising edge until the frame strobe.
module irq_frame_src (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic frame,
    output logic fire
);
    typedef struct packed {
        logic prev;
        logic armed;
    } src_st_t;

    src_st_t st_d, st_q;
    logic    rise;

    always_comb begin
        rise        = evt & ~st_q.prev;
        fire        = frame & (st_q.armed | rise);
        st_d.prev   = evt;
        st_d.armed  = (st_q.armed | rise) & ~fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/irq_err_sum.sv
// Error summary: latches status, ORs enabled inputs, fires on the rising OR.
module irq_err_sum #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] err,
    input  logic [N-1:0] en,
    input  logic         rd_clr,
    output logic [N-1:0] status,
    output logic         fire
);
    typedef struct packed {
        logic [N-1:0] status;
        logic         prev_any;
    } err_st_t;

    err_st_t st_d, st_q;
    logic    any_en;

    always_comb begin
        any_en        = |(err & en);
        fire          = any_en & ~st_q.prev_any;
        st_d.prev_any = any_en;
        st_d.status   = rd_clr ? err : (st_q.status | err);
        status        = st_q.status;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/irq_gather.sv
module irq_gather
    import irq_gather_pkg::*;
#(
    parameter int unsigned NCH    = 3,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DW     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    tx_frame,
    input  logic [NCH-1:0]    rx_frame,
    input  logic [NCH-1:0]    tx_evt,
    input  logic [NCH-1:0]    rx_evt,
    input  logic [NCH-1:0]    tx_err,
    input  logic [NCH-1:0]    rx_err,
    input  logic              pll_err,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [DW-1:0]     reg_rdata,
    output logic              irq_oe,
    output logic              irq_drv
);
    localparam int unsigned NFR  = 2 * NCH;
    localparam int unsigned NSRC = NFR + 2;
    localparam int unsigned ESW  = NFR + 1;

    typedef struct packed {
        logic [NSRC-1:0] mask;
        logic [NSRC-1:0] req;
        logic [ESW-1:0]  een;
        logic            oe;
        logic [DW-1:0]   rdata;
    } top_st_t;

    top_st_t         st_d, st_q;
    logic [NFR-1:0]  frame_fire;
    logic [NFR-1:0]  frame_vec;
    logic            tx_err_fire, rx_err_fire;
    logic [NCH-1:0]  tx_status;
    logic [NCH:0]    rx_status;
    logic [ESW-1:0]  err_status;
    logic [ESW-1:0]  err_vec;
    logic [NSRC-1:0] set_vec;
    logic [NSRC-1:0] req_now;
    logic [NSRC-1:0] clr_keep;
    reg_sel_e        sel;
    logic            rd_estat;

    assign frame_vec = {rx_frame, tx_frame};
    assign err_vec   = {pll_err, rx_err, tx_err};

    // address decode
    always_comb begin
        if      (reg_addr == ADDR_W'(OFF_MASK))  sel = SEL_MASK;
        else if (reg_addr == ADDR_W'(OFF_REQ))   sel = SEL_REQ;
        else if (reg_addr == ADDR_W'(OFF_CLR))   sel = SEL_CLR;
        else if (reg_addr == ADDR_W'(OFF_ESTAT)) sel = SEL_ESTAT;
        else if (reg_addr == ADDR_W'(OFF_EEN))   sel = SEL_EEN;
        else                                     sel = SEL_NONE;
    end

    assign rd_estat = reg_rd && (sel == SEL_ESTAT);

    // frame-aligned sources
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        irq_frame_src u_tx (
            .clk   (clk),
            .rst_n (rst_n),
            .evt   (tx_evt[g]),
            .frame (tx_frame[g]),
            .fire  (frame_fire[g])
        );
        irq_frame_src u_rx (
            .clk   (clk),
            .rst_n (rst_n),
            .evt   (rx_evt[g]),
            .frame (rx_frame[g]),
            .fire  (frame_fire[NCH+g])
        );
    end

    // error summaries
    irq_err_sum #(.N(NCH)) u_tx_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .err    (tx_err),
        .en     (st_q.een[NCH-1:0]),
        .rd_clr (rd_estat),
        .status (tx_status),
        .fire   (tx_err_fire)
    );

    irq_err_sum #(.N(NCH+1)) u_rx_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .err    ({pll_err, rx_err}),
        .en     (st_q.een[ESW-1:NCH]),
        .rd_clr (rd_estat),
        .status (rx_status),
        .fire   (rx_err_fire)
    );

    assign err_status = {rx_status, tx_status};
    assign set_vec    = {rx_err_fire, tx_err_fire, frame_fire};

    // next state
    always_comb begin
        st_d     = st_q;
        clr_keep = '1;

        if (reg_wr && sel == SEL_MASK) st_d.mask = reg_wdata[NSRC-1:0];
        if (reg_wr && sel == SEL_EEN)  st_d.een  = reg_wdata[ESW-1:0];
        if (reg_wr && sel == SEL_CLR)  clr_keep  = reg_wdata[NSRC-1:0];

        // a new event beats a clear in the same cycle
        st_d.req = (st_q.req & clr_keep) | set_vec;
        st_d.oe  = |(st_d.req & ~st_d.mask);

        if (reg_rd) begin
            unique case (sel)
                SEL_MASK:  st_d.rdata = DW'(st_q.mask);
                SEL_REQ:   st_d.rdata = DW'(st_q.req);
                SEL_ESTAT: st_d.rdata = DW'(err_status);
                SEL_EEN:   st_d.rdata = DW'(st_q.een);
                default:   st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask  <= '1;
            st_q.req   <= '0;
            st_q.een   <= '0;
            st_q.oe    <= 1'b0;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_now   = st_q.req;
    assign reg_rdata = st_q.rdata;
    assign irq_oe    = st_q.oe;
    assign irq_drv   = 1'b0;
endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk
    import irq_gather_pkg::*;
#(
    parameter int unsigned NSRC   = 8,
    parameter int unsigned NFR    = 6,
    parameter int unsigned ESW    = 7,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DW     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DW-1:0]     reg_wdata,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [DW-1:0]     reg_rdata,
    input logic              irq_oe,
    input logic [NFR-1:0]    frame_vec,
    input logic [NSRC-1:0]   set_vec,
    input logic [NSRC-1:0]   req,
    input logic [ESW-1:0]    err_vec,
    input logic [ESW-1:0]    err_status
);
    logic wr_clr, wr_all_mask, rd_stat, rd_unmapped;
    assign wr_clr      = reg_wr && reg_addr == ADDR_W'(OFF_CLR);
    assign wr_all_mask = reg_wr && reg_addr == ADDR_W'(OFF_MASK) && reg_wdata[NSRC-1:0] == '1;
    assign rd_stat     = reg_rd && reg_addr == ADDR_W'(OFF_ESTAT);
    assign rd_unmapped = reg_rd && reg_addr > ADDR_W'(OFF_LAST);

    // frame request bits rise only after a strobe of their own channel
    assert_frame_qual_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((req[NFR-1:0] & ~$past(req[NFR-1:0]) & ~$past(frame_vec)) == '0));

    assert_mask_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_all_mask |=> !irq_oe);

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((req & ~$past(set_vec)) ==
                    ($past(req) & $past(reg_wdata[NSRC-1:0]) & ~$past(set_vec))));

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> (($past(set_vec) & ~req) == '0));

    assert_status_rdclr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |=> (err_status == $past(err_vec)));

    assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_unmapped |=> (reg_rdata == '0));
endmodule

bind irq_gather irq_gather_chk #(
    .NSRC(NSRC), .NFR(NFR), .ESW(ESW), .ADDR_W(ADDR_W), .DW(DW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_rdata  (reg_rdata),
    .irq_oe     (irq_oe),
    .frame_vec  (frame_vec),
    .set_vec    (set_vec),
    .req        (req_now),
    .err_vec    (err_vec),
    .err_status (err_status)
);

// File: tb/irq_gather_tb.sv
`timescale 1ns/1ps
module irq_gather_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] src_evt = '0;
    logic [5:0] src_frame = '0;
    logic [6:0] err_in = '0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_rdata;
    logic       irq_oe, irq_drv;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    irq_gather u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_frame  (src_frame[2:0]),
        .rx_frame  (src_frame[5:3]),
        .tx_evt    (src_evt[2:0]),
        .rx_evt    (src_evt[5:3]),
        .tx_err    (err_in[2:0]),
        .rx_err    (err_in[5:3]),
        .pll_err   (err_in[6]),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_rdata (reg_rdata),
        .irq_oe    (irq_oe),
        .irq_drv   (irq_drv)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic strobe(input int i);
        @(negedge clk);
        src_frame[i] = 1'b1;
        @(negedge clk);
        src_frame = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd(8'd0, d); chk("R1 mask after reset", d, 8'hFF);
        rd(8'd4, d); chk("R1 error enable after reset", d, 8'h00);
        rd(8'd1, d); chk("R1 request after reset", d, 8'h00);
        chk("R1 irq_oe after reset", irq_oe, 1'b0);
        chk("R5 irq_drv constant", irq_drv, 1'b0);

        // frame sources, one at a time
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); src_evt[i] = 1'b1;
            rd(8'd1, d); chk($sformatf("R3 src%0d no strobe", i), d, 8'h00);
            strobe(i);
            chk($sformatf("R5 src%0d masked oe", i), irq_oe, 1'b0);
            rd(8'd1, d); chk($sformatf("R2 R3 src%0d bit", i), d, 8'(1 << i));
            wr(8'd0, ~8'(1 << i));
            chk($sformatf("R5 src%0d unmasked oe", i), irq_oe, 1'b1);
            wr(8'd2, 8'hFF);
            rd(8'd1, d); chk($sformatf("R6 src%0d clear ones keep", i), d, 8'(1 << i));
            wr(8'd2, ~8'(1 << i));
            rd(8'd1, d); chk($sformatf("R6 src%0d cleared", i), d, 8'h00);
            chk($sformatf("R5 src%0d oe released", i), irq_oe, 1'b0);
            strobe(i);
            rd(8'd1, d); chk($sformatf("R4 src%0d level no reset", i), d, 8'h00);
            @(negedge clk); src_evt[i] = 1'b0;
            @(negedge clk); src_evt[i] = 1'b1; src_frame[i] = 1'b1;
            @(negedge clk); src_frame = '0;
            rd(8'd1, d); chk($sformatf("R3 R4 src%0d same-cycle rise", i), d, 8'(1 << i));
            wr(8'd2, 8'h00);
            wr(8'd0, 8'hFF);
            @(negedge clk); src_evt[i] = 1'b0;
        end

        // set beats clear
        @(negedge clk); src_evt[0] = 1'b1;
        @(negedge clk);
        src_frame[0] = 1'b1; reg_addr = 8'd2; reg_wdata = 8'h00; reg_wr = 1'b1;
        @(negedge clk);
        src_frame = '0; reg_wr = 1'b0; src_evt[0] = 1'b0;
        rd(8'd1, d); chk("R7 set wins over clear", d, 8'h01);

        // two pending: oe holds until last unmasked is cleared
        @(negedge clk); src_evt[3] = 1'b1;
        strobe(3);
        @(negedge clk); src_evt[3] = 1'b0;
        wr(8'd0, 8'hF6);
        chk("R5 two pending oe", irq_oe, 1'b1);
        wr(8'd2, 8'hFE);
        chk("R5 one still pending oe", irq_oe, 1'b1);
        wr(8'd2, 8'hF7);
        chk("R5 none pending oe", irq_oe, 1'b0);
        wr(8'd0, 8'hFF);

        // error inputs, enabled and disabled (others enabled)
        rd(8'd3, d); chk("R9 status empty", d, 8'h00);
        for (int j = 0; j < 7; j++) begin
            for (int en = 0; en < 2; en++) begin
                wr(8'd4, (en != 0) ? 8'(1 << j) : (~8'(1 << j) & 8'h7F));
                @(negedge clk); err_in[j] = 1'b1;
                @(negedge clk); err_in = '0;
                rd(8'd1, d);
                chk($sformatf("R8 err%0d en=%0d request", j, en), d,
                    (en != 0) ? ((j < 3) ? 8'h40 : 8'h80) : 8'h00);
                rd(8'd3, d); chk($sformatf("R9 err%0d en=%0d status", j, en), d, 8'(1 << j));
                rd(8'd3, d); chk($sformatf("R9 err%0d cleared by read", j), d, 8'h00);
                wr(8'd2, 8'h00);
            end
        end
        wr(8'd4, 8'h00);

        // error in the cycle of a status read stays latched
        @(negedge clk);
        reg_addr = 8'd3; reg_rd = 1'b1; err_in[1] = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0; err_in = '0; d = reg_rdata;
        chk("R9 read returns prior contents", d, 8'h00);
        rd(8'd3, d); chk("R9 error during read retained", d, 8'h02);

        // register port edges
        rd(8'd2, d); chk("R6 clear reads zero", d, 8'h00);
        rd(8'd7, d); chk("R10 unmapped reads zero", d, 8'h00);
        wr(8'd1, 8'hFF);
        rd(8'd1, d); chk("R10 request write ignored", d, 8'h00);
        wr(8'd3, 8'hFF);
        rd(8'd3, d); chk("R10 status write ignored", d, 8'h00);
        wr(8'd4, 8'h55);
        rd(8'd4, d); chk("R8 enable readback", d, 8'h55);
        repeat (3) @(negedge clk);
        chk("R10 read data held", reg_rdata, 8'h55);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule